// File: doc/BRIEF.md
# LCD Row-Scan and Blink Timing Generator

This block turns the master oscillator clock of a multiplexed dot-matrix LCD controller into its scan timing. A duty-mode input chooses between two panel types. The short mode scans 9 commons and the full mode scans 17 commons. The row period changes with the mode so that a frame lasts about the same time in both modes. The block reports which common is active. It also drives a frame-rate polarity signal for AC drive, and a blink phase of about 1 Hz that is built from a 5×2^14-clock cycle.

Alongside the scan, a small gating stage decides how the segment data of the character being shown is to be presented. When the display is off, the gating stage forces everything to the inactive level. During the active blink phase, a character flagged as blinking is shown either all dark or all lit, chosen by a pattern-select input. In every other case the glyph passes through unchanged. The segment shifter and the glyph generator downstream use the common select, the polarity and the segment control code. The analog bias levels are not part of this block.

Top module: `lcd_scan_timer`

## Requirements
- R1: After reset, com_idx_o is 0, pol_o is 0 and blink_o is 0.
- R2: With duty9_i=1, each common stays active for 128 clocks. The commons are scanned in ascending order 0..8 and then wrap to 0, so a frame is 1152 clocks.
- R3: With duty9_i=0, each common stays active for 64 clocks. The commons are scanned in ascending order 0..16 and then wrap to 0, so a frame is 1088 clocks.
- R4: With duty9_i=1, commons 9..16 (com_sel_o bits 9..16) are never selected. The duty mode is held static between resets.
- R5: pol_o toggles exactly at each frame boundary and at no other time.
- R6: Every 40960 clocks (half of 5×2^14) a blink toggle becomes pending. blink_o flips at the first frame boundary at or after that point. blink_o never changes except at a frame boundary.
- R7: When disp_on_i=1, com_sel_o is one-hot with bit k set for active common k. When disp_on_i=0, com_sel_o is all zero. The scan, the polarity and the blink phase keep running in both cases.
- R8: seg_ctl_o codes are 0 for normal, 1 for dark, 2 for lit and 3 for blank. With disp_on_i=0 the code is 3. With the display on, blink_o=1 and char_blink_i=1, the code is 1 when blink_dark_i=1 and 2 when blink_dark_i=0.
- R9: With the display on, the code is 0 when either blink_o=0 or char_blink_i=0, whatever the value of blink_dark_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty9_i | input | 1 | 1: 9-common mode, 0: 17-common mode |
| disp_on_i | input | 1 | Display enable |
| blink_dark_i | input | 1 | Blink pattern: 1 dark, 0 fully lit |
| char_blink_i | input | 1 | Blink flag of the character being shown |
| com_idx_o | output | 5 | Index of the active common, 0-based |
| com_sel_o | output | 17 | One-hot common select, gated by display enable |
| pol_o | output | 1 | Frame-inversion polarity |
| blink_o | output | 1 | Blink phase, 1 = override active |
| seg_ctl_o | output | 2 | Segment presentation code |

## Verification
The common index, the polarity and the blink phase are registered. The value seen at a sample point after n rising edges since reset release is a closed-form function of n: the row index is (n/row)%commons and the polarity is (n/frame)%2. The blink phase flips at the frame boundary edge ceil(40960·m/frame)·frame. The common select and the segment control are combinational in the inputs and the current blink phase, so they are due in the same cycle the inputs change. For each cycle, the bench predicts one entry just after the rising edge, once the new inputs have been driven. It compares that entry at the falling edge of the same cycle, so every check lands exactly n edges after release.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    SEG_NORMAL = 2'd0,
    SEG_DARK   = 2'd1,
    SEG_LIT    = 2'd2,
    SEG_BLANK  = 2'd3
  } seg_ctl_e;

  function automatic seg_ctl_e seg_decide(input logic disp_on, input logic blink_ph,
                                          input logic char_blink, input logic dark_pat);
    if (!disp_on) return SEG_BLANK;
    if (blink_ph && char_blink) return dark_pat ? SEG_DARK : SEG_LIT;
    return SEG_NORMAL;
  endfunction
endpackage

// File: rtl/lcd_row_scan.sv
module lcd_row_scan #(
  parameter int ROW_CLKS_SHORT = 128,
  parameter int ROW_CLKS_FULL  = 64,
  parameter int COMS_SHORT     = 9,
  parameter int COMS_FULL      = 17,
  localparam int CW = $clog2(COMS_FULL),
  localparam int RMAX = (ROW_CLKS_SHORT > ROW_CLKS_FULL) ? ROW_CLKS_SHORT : ROW_CLKS_FULL,
  localparam int RW = $clog2(RMAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          duty9_i,
  output logic [CW-1:0] com_idx_o,
  output logic          frame_end_o
);
  localparam logic [RW-1:0] ROW_LAST_S = RW'(ROW_CLKS_SHORT - 1);
  localparam logic [RW-1:0] ROW_LAST_F = RW'(ROW_CLKS_FULL - 1);
  localparam logic [CW-1:0] COM_LAST_S = CW'(COMS_SHORT - 1);
  localparam logic [CW-1:0] COM_LAST_F = CW'(COMS_FULL - 1);

  logic [RW-1:0] row_q;
  logic [CW-1:0] com_q;
  logic          row_end, com_end;

  // >= keeps the counters bounded if the mode flips mid-row
  assign row_end     = row_q >= (duty9_i ? ROW_LAST_S : ROW_LAST_F);
  assign com_end     = com_q >= (duty9_i ? COM_LAST_S : COM_LAST_F);
  assign frame_end_o = row_end && com_end;
  assign com_idx_o   = com_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      com_q <= '0;
    end else if (row_end) begin
      row_q <= '0;
      com_q <= com_end ? '0 : com_q + 1'b1;
    end else begin
      row_q <= row_q + 1'b1;
    end
  end

  // R2
  com_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_end |=> com_q == $past(com_q));
  // R3
  com_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_q <= COM_LAST_F);
  // R4
  short_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty9_i |-> com_q <= COM_LAST_S);
endmodule

// File: rtl/lcd_frame_flags.sv
module lcd_frame_flags #(
  parameter int BLINK_HALF_CLKS = 40960,
  localparam int BW = $clog2(BLINK_HALF_CLKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_end_i,
  output logic pol_o,
  output logic blink_o
);
  logic [BW-1:0] bcnt_q;
  logic          pend_q, pol_q, blink_q, bwrap;

  assign bwrap   = bcnt_q == BW'(BLINK_HALF_CLKS - 1);
  assign pol_o   = pol_q;
  assign blink_o = blink_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q  <= '0;
      pend_q  <= 1'b0;
      pol_q   <= 1'b0;
      blink_q <= 1'b0;
    end else begin
      bcnt_q <= bwrap ? '0 : bcnt_q + 1'b1;
      pend_q <= (pend_q | bwrap) & ~frame_end_i;
      if (frame_end_i) begin
        pol_q <= ~pol_q;
        if (pend_q | bwrap) blink_q <= ~blink_q;
      end
    end
  end

  // R5
  pol_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> pol_q != $past(pol_q));
  // R5
  pol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(pol_q));
  // R6
  blink_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(blink_q));
endmodule

// File: rtl/lcd_seg_gate.sv
module lcd_seg_gate
  import lcd_scan_pkg::*;
#(
  parameter int COMS_FULL = 17,
  localparam int CW = $clog2(COMS_FULL)
) (
  input  logic [CW-1:0]        com_idx_i,
  input  logic                 disp_on_i,
  input  logic                 blink_i,
  input  logic                 char_blink_i,
  input  logic                 dark_pat_i,
  output logic [COMS_FULL-1:0] com_sel_o,
  output seg_ctl_e             seg_ctl_o
);
  for (genvar k = 0; k < COMS_FULL; k++) begin : g_com
    assign com_sel_o[k] = disp_on_i && (com_idx_i == CW'(k));
  end

  assign seg_ctl_o = seg_decide(disp_on_i, blink_i, char_blink_i, dark_pat_i);
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int ROW_CLKS_SHORT  = 128,
  parameter int ROW_CLKS_FULL   = 64,
  parameter int COMS_SHORT      = 9,
  parameter int COMS_FULL       = 17,
  parameter int BLINK_HALF_CLKS = 40960,
  localparam int CW = $clog2(COMS_FULL)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 duty9_i,
  input  logic                 disp_on_i,
  input  logic                 blink_dark_i,
  input  logic                 char_blink_i,
  output logic [CW-1:0]        com_idx_o,
  output logic [COMS_FULL-1:0] com_sel_o,
  output logic                 pol_o,
  output logic                 blink_o,
  output logic [1:0]           seg_ctl_o
);
  logic     frame_end;
  seg_ctl_e seg_ctl;

  lcd_row_scan #(
    .ROW_CLKS_SHORT(ROW_CLKS_SHORT), .ROW_CLKS_FULL(ROW_CLKS_FULL),
    .COMS_SHORT(COMS_SHORT), .COMS_FULL(COMS_FULL)
  ) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty9_i(duty9_i),
    .com_idx_o(com_idx_o), .frame_end_o(frame_end)
  );

  lcd_frame_flags #(.BLINK_HALF_CLKS(BLINK_HALF_CLKS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(frame_end),
    .pol_o(pol_o), .blink_o(blink_o)
  );

  lcd_seg_gate #(.COMS_FULL(COMS_FULL)) u_gate (
    .com_idx_i(com_idx_o), .disp_on_i(disp_on_i), .blink_i(blink_o),
    .char_blink_i(char_blink_i), .dark_pat_i(blink_dark_i),
    .com_sel_o(com_sel_o), .seg_ctl_o(seg_ctl)
  );

  assign seg_ctl_o = seg_ctl;

  // R7
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(com_sel_o));
  // R7
  sel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_on_i |-> com_sel_o == '0);
  // R9
  seg_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_on_i && !blink_o) |-> seg_ctl_o == 2'd0);
endmodule

// File: tb/lcd_scan_timer_tb_top.sv
module lcd_scan_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 40960;
  localparam int RUN_CYCLES = 85000;
  localparam int WATCHDOG = 199000;

  typedef struct {
    int n;
    logic [4:0] idx;
    logic [16:0] sel;
    logic pol;
    logic blink;
    logic [1:0] seg;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic duty9 = 1'b1, disp_on = 1'b0, dark = 1'b0, cblink = 1'b0;
  logic [4:0] com_idx;
  logic [16:0] com_sel;
  logic pol, blink;
  logic [1:0] seg_ctl;

  int errors = 0, checks = 0;
  exp_t sb_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .duty9_i(duty9), .disp_on_i(disp_on),
    .blink_dark_i(dark), .char_blink_i(cblink), .com_idx_o(com_idx),
    .com_sel_o(com_sel), .pol_o(pol), .blink_o(blink), .seg_ctl_o(seg_ctl)
  );

  // reference state for the blink phase
  int m_next, tog_at;
  logic m_blink;

  function automatic exp_t predict(int n);
    exp_t e;
    int rows, ncom, frame;
    rows  = duty9 ? 128 : 64;   // R2 / R3
    ncom  = duty9 ? 9 : 17;
    frame = rows * ncom;
    e.n   = n;
    e.idx = 5'((n / rows) % ncom);
    e.pol = 1'((n / frame) % 2);  // R5
    e.blink = m_blink;
    e.sel = disp_on ? (17'd1 << e.idx) : 17'd0;  // R7
    if (!disp_on) e.seg = 2'd3;                  // R8
    else if (m_blink && cblink) e.seg = dark ? 2'd1 : 2'd2;
    else e.seg = 2'd0;                           // R9
    return e;
  endfunction

  function automatic int next_toggle(int m, int frame);
    return ((HALF * m + frame - 1) / frame) * frame;  // R6
  endfunction

  task automatic run_mode(input logic mode);
    int frame;
    duty9 = mode;
    disp_on = 1'b1; dark = 1'b0; cblink = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    frame = mode ? 1152 : 1088;
    m_blink = 1'b0; m_next = 1; tog_at = next_toggle(1, frame);
    sb_q.push_back(predict(0));  // R1 reset state
    fork
      begin : driver
        for (int n = 1; n <= RUN_CYCLES; n++) begin
          @(posedge clk); #1;
          disp_on = ($urandom % 4) != 0;
          dark    = 1'($urandom);
          cblink  = 1'($urandom);
          if (n == tog_at) begin
            m_blink = ~m_blink;
            m_next++;
            tog_at = next_toggle(m_next, frame);
          end
          sb_q.push_back(predict(n));
        end
      end
      begin : monitor
        for (int n = 0; n <= RUN_CYCLES; n++) begin
          exp_t e;
          if (n > 0) @(negedge clk);
          if (sb_q.size() == 0) begin
            errors++; checks++;
            $display("FAIL R2 scoreboard empty at n=%0d: actual size 0 expected 1", n);
          end else begin
            e = sb_q.pop_front();
            checks++;
            if (com_idx !== e.idx || pol !== e.pol || blink !== e.blink) begin
              errors++;
              $display("FAIL %s n=%0d duty9=%0b: actual idx=%0d pol=%0b blink=%0b expected idx=%0d pol=%0b blink=%0b",
                       (n == 0) ? "R1" : (blink !== e.blink) ? "R6" : (pol !== e.pol) ? "R5" :
                       (mode ? "R2" : "R3"), n, mode, com_idx, pol, blink, e.idx, e.pol, e.blink);
            end
            checks++;
            if (com_sel !== e.sel) begin
              errors++;
              $display("FAIL %s n=%0d: actual sel=%h expected sel=%h",
                       (mode && com_sel[16:9] != 0) ? "R4" : "R7", n, com_sel, e.sel);
            end
            checks++;
            if (seg_ctl !== e.seg) begin
              errors++;
              $display("FAIL %s n=%0d: actual seg=%0d expected seg=%0d",
                       (e.seg == 2'd0) ? "R9" : "R8", n, seg_ctl, e.seg);
            end
          end
        end
      end
    join
  endtask

  initial begin
    run_mode(1'b1);
    run_mode(1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule